// File: doc/BRIEF.md
# Two-Wire DAC Control Slave

This block is a receive-only slave on a two-wire, I2C-compatible bus. It holds the 8-bit code for a DAC and a shutdown flag. It samples the bus lines with the system clock and filters them. It then detects START, repeated START and STOP conditions. It answers one 7-bit address, which is built from a fixed 5-bit prefix and a 2-bit option parameter.

The last bit of the address byte is not a read/write bit. It requests shutdown (1) or normal operation (0). When that bit is 0, the master writes one data byte that holds the new code. When it is 1, the master clocks a byte out of the slave. The slave leaves SDA released during that byte, so the master reads all ones.

Nothing reaches the outputs until a STOP arrives after a complete second byte. A probe that sends only the address byte is acknowledged and has no effect.

Top module: `dac_link_slave`

## Requirements
- R1: After reset, `dac_code` is 0x00 and `shdn`, `out_pd` and `sda_pull` are all 0.
- R2: The slave acknowledges an address byte whose upper seven bits equal {5'b01100, OPT}, whatever the value of bit 0. It acknowledges by asserting `sda_pull` during the ninth SCL high phase. With OPT=01 the address bytes are 0x62 and 0x63.
- R3: Other address bytes get no acknowledge and change nothing. This covers the other options, general call 0x00 and the 10-bit prefix 0xF0.
- R4: When bit 0 of the address byte is 0, the slave acknowledges the second byte. That byte is taken MSB first as the new code. At the next STOP, `dac_code` takes the byte and `shdn` clears.
- R5: After a STOP that follows the address acknowledge directly, `dac_code` and `shdn` are unchanged.
- R6: When bit 0 of the address byte is 1, the slave never asserts `sda_pull` during the eight data bits of the second byte. At the STOP, `shdn` and `out_pd` go to 1 and `dac_code` keeps its value.
- R7: A repeated START discards a pending update. A new address byte, a second byte and a STOP are then required.
- R8: Bytes after the second byte get no acknowledge. A STOP after them still commits the second byte.
- R9: `dac_code` and `shdn` change only in the cycle after a STOP is detected.
- R10: A one-clock pulse on SDA while SCL is high is not seen as START or STOP.
- R11: Whether the master acknowledges the read byte or not, the shutdown update still happens at STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_pull | output | 1 | 1 drives SDA low (open drain) |
| dac_code | output | 8 | Code for the DAC |
| shdn | output | 1 | Shutdown state |
| out_pd | output | 1 | Enables the output pull-down while in shutdown |

## Verification
Two cases are hard to reach from the ports. The first is a pending update that is thrown away. To reach it, the bench completes a data byte and checks that the code has not yet moved. It then issues a repeated START and an address-only probe, and confirms that the old code survives.

The second is a spurious bus condition. To reach it, the bench drops SDA for exactly one system clock while SCL is high in the middle of a data bit. It then checks that the transfer still completes with the intended code.

// File: rtl/dac_link_slave.sv
module dac_link_slave #(
  parameter logic [1:0] OPT = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  output logic [7:0] dac_code,
  output logic       shdn,
  output logic       out_pd
);
  localparam logic [6:0] MY_ADDR = {5'b01100, OPT};

  typedef enum logic [1:0] {P_IDLE, P_ADDR, P_DATA, P_DONE} phase_t;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  logic [1:0] scl_s, sda_s;
  logic [2:0] scl_h, sda_h;
  logic       scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[1:0], scl_s[1]};
      sda_h <= {sda_h[1:0], sda_s[1]};
      scl_f <= maj3(scl_h);
      sda_f <= maj3(sda_h);
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire start_c = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c  = scl_f & scl_q & ~sda_q & sda_f;
  wire scl_up  = scl_f & ~scl_q;
  wire scl_dn  = ~scl_f & scl_q;

  phase_t     phase;
  logic [3:0] cnt;
  logic [7:0] shr, pend_code;
  logic       mode_sd, pend, ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      cnt       <= '0;
      shr       <= '0;
      pend_code <= '0;
      mode_sd   <= 1'b0;
      pend      <= 1'b0;
      ack       <= 1'b0;
      dac_code  <= '0;
      shdn      <= 1'b0;
    end else if (start_c) begin
      phase <= P_ADDR;
      cnt   <= '0;
      ack   <= 1'b0;
      pend  <= 1'b0;
    end else if (stop_c) begin
      phase <= P_IDLE;
      ack   <= 1'b0;
      pend  <= 1'b0;
      if (pend) begin
        shdn <= mode_sd;
        if (!mode_sd) dac_code <= pend_code;
      end
    end else if (scl_up && (phase == P_ADDR || phase == P_DATA) && cnt < 4'd8) begin
      shr <= {shr[6:0], sda_f};
      cnt <= cnt + 4'd1;
    end else if (scl_dn) begin
      if (cnt == 4'd8) begin
        cnt <= 4'd9;
        if (phase == P_ADDR) begin
          if (shr[7:1] == MY_ADDR) begin
            ack     <= 1'b1;
            mode_sd <= shr[0];
          end else begin
            phase <= P_IDLE;
          end
        end else if (phase == P_DATA) begin
          ack       <= ~mode_sd;
          pend      <= 1'b1;
          pend_code <= shr;
        end
      end else if (cnt == 4'd9) begin
        cnt <= '0;
        ack <= 1'b0;
        if (phase == P_ADDR) phase <= P_DATA;
        else if (phase == P_DATA) phase <= P_DONE;
      end
    end
  end

  assign sda_pull = ack;
  assign out_pd   = shdn;

  assert_code_at_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_c |=> $stable(dac_code));
  assert_shdn_at_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_c |=> $stable(shdn));
  assert_ack_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_f);
  assert_ack_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (phase == P_ADDR || phase == P_DATA));
  assert_sd_keeps_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shdn) |-> $stable(dac_code));
endmodule

// File: tb/test_dac_link_slave.sv
`timescale 1ns/1ps
module test_dac_link_slave;
  localparam int H = 10;
  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, shdn, out_pd;
  logic [7:0] dac_code;
  int vecs = 0, errs = 0;
  wire sda_line = sda_m & ~sda_pull;

  always #2.5 clk = ~clk;

  dac_link_slave #(.OPT(2'b01)) i_dac_link_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull(sda_pull), .dac_code(dac_code), .shdn(shdn), .out_pd(out_pd));

  // {addr, data, nbytes, exp_code, exp_shdn, exp_addr_ack}
  localparam logic [27:0] VEC [11] = '{
    {8'h62, 8'hA5, 2'd1, 8'hA5, 1'b0, 1'b1},
    {8'h60, 8'h11, 2'd1, 8'hA5, 1'b0, 1'b0},
    {8'h63, 8'h00, 2'd1, 8'hA5, 1'b1, 1'b1},
    {8'h62, 8'h3C, 2'd1, 8'h3C, 1'b0, 1'b1},
    {8'h00, 8'hFF, 2'd1, 8'h3C, 1'b0, 1'b0},
    {8'hF0, 8'h01, 2'd1, 8'h3C, 1'b0, 1'b0},
    {8'h62, 8'h00, 2'd0, 8'h3C, 1'b0, 1'b1},
    {8'h63, 8'h00, 2'd0, 8'h3C, 1'b0, 1'b1},
    {8'h62, 8'h80, 2'd2, 8'h80, 1'b0, 1'b1},
    {8'h66, 8'h42, 2'd1, 8'h80, 1'b0, 1'b0},
    {8'h62, 8'h01, 2'd1, 8'h01, 1'b0, 1'b1}
  };

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(2 * H);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic glitch, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H);
      scl_m = 1'b1; wt(H / 2);
      if (glitch && i == 7) begin
        sda_m = ~b[i]; wt(1); sda_m = b[i];
      end
      wt(H / 2);
      scl_m = 1'b0; wt(2);
    end
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H / 2);
    acked = sda_pull;
    wt(H / 2);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic read_byte(input logic mack, output logic pulled);
    pulled = 1'b0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(H);
      scl_m = 1'b1; wt(H / 2);
      pulled = pulled | sda_pull;
      wt(H / 2);
      scl_m = 1'b0; wt(2);
    end
    sda_m = ~mack; wt(H);
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic check_out(input string req, input logic [7:0] c, input logic s);
    check(dac_code == c, req, dac_code, c);
    check(shdn == s, req, shdn, s);
    check(out_pd == s, req, out_pd, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic a, p;
    wt(5);
    check(dac_code == 8'h00, "R1", dac_code, 0);
    check(shdn == 1'b0 && out_pd == 1'b0, "R1", shdn, 0);
    check(sda_pull == 1'b0, "R1", sda_pull, 0);
    rst_n = 1'b1; wt(10);

    for (int k = 0; k < 11; k++) begin
      logic [27:0] v;
      string tag;
      v = VEC[k];
      if (!v[0]) tag = "R3";
      else if (v[11:10] == 2'd0) tag = "R5";
      else if (v[20]) tag = "R6";
      else if (v[11:10] == 2'd2) tag = "R8";
      else tag = "R4";
      bus_start();
      send_byte(v[27:20], 1'b0, a);
      check(a == v[0], v[0] ? "R2" : "R3", a, v[0]);
      if (v[11:10] != 2'd0) begin
        if (v[20] && v[0]) begin
          read_byte(1'b0, p);
          check(p == 1'b0, "R6", p, 0);
        end else begin
          send_byte(v[19:12], 1'b0, a);
          if (v[0]) check(a == 1'b1, "R4", a, 1);
          if (v[11:10] == 2'd2) begin
            send_byte(8'h55, 1'b0, a);
            check(a == 1'b0, "R8", a, 0);
          end
        end
      end
      bus_stop();
      check_out(tag, v[9:2], v[1]);
    end

    // R7 and R9: pending update dropped by repeated START
    bus_start();
    send_byte(8'h62, 1'b0, a);
    send_byte(8'h77, 1'b0, a);
    wt(H);
    check(dac_code == 8'h01, "R9", dac_code, 8'h01);
    bus_rstart();
    send_byte(8'h62, 1'b0, a);
    check(a == 1'b1, "R7", a, 1);
    bus_stop();
    check_out("R7", 8'h01, 1'b0);
    bus_start();
    send_byte(8'h62, 1'b0, a);
    send_byte(8'h44, 1'b0, a);
    bus_rstart();
    send_byte(8'h62, 1'b0, a);
    send_byte(8'h99, 1'b0, a);
    bus_stop();
    check_out("R7", 8'h99, 1'b0);

    // R10: one-clock SDA glitch while SCL high
    bus_start();
    send_byte(8'h62, 1'b0, a);
    send_byte(8'h9C, 1'b1, a);
    check(a == 1'b1, "R10", a, 1);
    bus_stop();
    check_out("R10", 8'h9C, 1'b0);

    // R11: read byte acknowledged by master still commits shutdown
    bus_start();
    send_byte(8'h63, 1'b0, a);
    read_byte(1'b1, p);
    bus_stop();
    check_out("R11", 8'h9C, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule